// File: doc/BRIEF.md
# Pattern-Checker Word and Error Tally

This block sits behind a pattern checker on a serial receive lane. Each clock, the checker presents a word-valid strobe and a per-bit mismatch mask. The block keeps two saturating accumulators. One counts every valid word that passes through. The other counts valid words that carry at least one mismatched bit. Both counts are in whole words. Software turns the word count into a bit count by multiplying by the word width.

Software reaches the block over a byte-wide register bus. A control register at offset 0x300 holds three bits:
- a level enable that gates counting, so errors can be gathered over chosen intervals;
- a level clear that zeroes everything and holds the checker's pattern generator in reset;
- a self-clearing capture bit.

Reads never see the live counters. They see a pair of readback registers that load both counters in the same cycle. The load happens on every cycle while counting is enabled, or once on a capture request. Because of this, a slow multi-byte read always returns a word count and an error count taken at the same instant.

A read-only lock flag tells software when the checker has run long enough without errors to be trusted.

Top module: `lane_err_tally`

## Requirements
- R1: The control register is at offset 0x300. Bit 0 is enable, bit 1 is clear and bit 2 is capture. Bit 3 is the read-only lock flag, and bits 7:4 read 0. Enable and clear read back as last written. Capture always reads back 0.
- R2: While enable is 1 and clear is 0, the word accumulator rises by exactly one for each cycle with word_vld high. Cycles with word_vld low are not counted, whatever err_mask holds.
- R3: Under the same gating, the error accumulator rises by exactly one for each valid word whose err_mask has any bit set. One set bit and all bits set count the same.
- R4: While enable is 0, both accumulators and both readback registers keep their values, even when valid errored words arrive.
- R5: While clear is 1, the following hold:
  - chk_reset is high;
  - counting is suppressed;
  - one cycle after clear is seen, both accumulators, both readback registers and the lock flag are 0.
- R6: The readback registers load both accumulators in the same cycle. This happens on every cycle with enable 1, and on the cycle after a write of 1 to bit 2. A word reaches the readback two clock edges after it is presented.
- R7: The error count reads from offsets 0x301 to 0x307 and the word count from offsets 0x308 to 0x30E. In each, the lowest offset holds bits 7:0, continuing little-endian. Bits at or above CNT_W read 0.
- R8: Each accumulator stops at 2^CNT_W-1 and does not wrap.
- R9: The lock flag sets once LOCK_WORDS consecutive valid error-free words arrive while enabled. A valid errored word, or enable going low, restarts that run. Once set, the flag stays set until clear.
- R10: Reads from any other offset return 0. Writes to any offset other than 0x300 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_vld | input | 1 | Checker presents a compared word this cycle |
| err_mask | input | WORD_W | Per-bit mismatch mask for the presented word |
| reg_addr | input | ADDR_W | Register offset for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| chk_reset | output | 1 | Holds the checker's pattern generator in reset |
| lock_done | output | 1 | Lock flag, same as control bit 3 |

## Verification
The hardest states to reach from the ports are saturation and a lock run that breaks just short of completion. With the default 50-bit counters, saturation can never be reached. The bench therefore narrows CNT_W to 10, keeping the seven-byte map, and streams 1030 errored words. This shows both counts pinned at 1023, with the upper bits of the top bytes reading zero. For the lock flag, the bench sends 63 clean words and then one errored word, then 63 more clean words. This proves the run restarted, and a 64th clean word then sets the flag.

// File: rtl/lane_err_tally_pkg.sv
// Package: shared control-register bit positions and the decoded control type.
// Assumes an 8-bit register bus.
package lane_err_tally_pkg;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_CLR_BIT  = 1;
    localparam int CTL_CAP_BIT  = 2;
    localparam int CTL_LOCK_BIT = 3;

    typedef struct packed {
        logic enable;
        logic clear;
    } ctl_t;

endpackage

// File: rtl/lte_ctrl_regs.sv
// Control register. Holds the level enable and clear bits and turns a write
// of the capture bit into a single-cycle pulse.
// Assumes one write per cycle at most.
module lte_ctrl_regs
    import lane_err_tally_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [2:0]        wbits,
    output ctl_t              ctl,
    output logic              cap_pulse
);

    logic hit;
    assign hit = reg_wr && (reg_addr == CTRL_ADDR);

    // Latch level bits on a control write; the capture pulse lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl       <= '0;
            cap_pulse <= 1'b0;
        end else begin
            cap_pulse <= 1'b0;
            if (hit) begin
                ctl.enable <= wbits[CTL_EN_BIT];
                ctl.clear  <= wbits[CTL_CLR_BIT];
                cap_pulse  <= wbits[CTL_CAP_BIT];
            end
        end
    end

    // R6
    cap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |-> $past(reg_wr && reg_addr == CTRL_ADDR && wbits[CTL_CAP_BIT]));

endmodule

// File: rtl/lte_sat_counter.sv
// Saturating up-counter with synchronous clear.
// Assumes clear has priority over increment.
module lte_sat_counter #(
    parameter int W = 50
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = '1;

    // Count up by one per increment, stopping at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && !clr) |=> cnt == TOP);

    // R2
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/lte_lock_qual.sv
// Lock qualifier. Counts consecutive clean valid words while enabled and
// raises a sticky flag at LOCK_WORDS.
// Assumes clear resets both the run and the flag.
module lte_lock_qual #(
    parameter int LOCK_WORDS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic enable,
    input  logic word_vld,
    input  logic word_bad,
    output logic done
);

    localparam int LC_W = $clog2(LOCK_WORDS + 1);
    localparam logic [LC_W-1:0] LAST = LC_W'(LOCK_WORDS - 1);

    logic [LC_W-1:0] run;

    // Track the clean-word run; set the flag on completing it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run  <= '0;
            done <= 1'b0;
        end else if (!enable) begin
            run <= '0;
        end else if (word_vld) begin
            if (word_bad) begin
                run <= '0;
            end else if (run == LAST) begin
                done <= 1'b1;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    // R9
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(enable && word_vld && !word_bad && !clr));

    // R5
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !done);

endmodule

// File: rtl/lte_snap_bank.sv
// Readback pair. Loads both accumulators together, so readback values
// always belong to one cycle.
// Assumes clear beats load.
module lte_snap_bank #(
    parameter int W = 50
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] pass_in,
    input  logic [W-1:0] err_in,
    output logic [W-1:0] pass_q,
    output logic [W-1:0] err_q
);

    // Copy both counters in the same edge, or clear them both.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pass_q <= '0;
            err_q  <= '0;
        end else if (load) begin
            pass_q <= pass_in;
            err_q  <= err_in;
        end
    end

    // R6
    pair_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q <= pass_q);

endmodule

// File: rtl/lane_err_tally.sv
// Top of the word and error tally. Gates counting by the control bits,
// feeds two saturating accumulators and a lock qualifier, and serves a
// byte-wide combinational read of control and readback registers.
// Assumes REG_BYTES*8 >= CNT_W and REG_BYTES <= 8.
module lane_err_tally
    import lane_err_tally_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int CNT_W      = 50,
    parameter int REG_BYTES  = 7,
    parameter int LOCK_WORDS = 64,
    parameter int ADDR_W     = 10,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h300,
    parameter logic [ADDR_W-1:0] ERR_BASE  = 10'h301,
    parameter logic [ADDR_W-1:0] PASS_BASE = 10'h308
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] err_mask,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              chk_reset,
    output logic              lock_done
);

    localparam int RB_W = 8 * REG_BYTES;

    ctl_t             ctl;
    logic             cap_pulse;
    logic             count_en;
    logic             word_bad;
    logic [CNT_W-1:0] pass_cnt;
    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W-1:0] pass_snap;
    logic [CNT_W-1:0] err_snap;
    logic [RB_W-1:0]  pass_wide;
    logic [RB_W-1:0]  err_wide;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[7:3];
    assign word_bad     = |err_mask;
    assign count_en     = ctl.enable && !ctl.clear && word_vld;
    assign chk_reset    = ctl.clear;

    lte_ctrl_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .wbits     (reg_wdata[2:0]),
        .ctl       (ctl),
        .cap_pulse (cap_pulse)
    );

    lte_sat_counter #(.W(CNT_W)) u_pass_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl.clear),
        .inc   (count_en),
        .cnt   (pass_cnt)
    );

    lte_sat_counter #(.W(CNT_W)) u_err_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl.clear),
        .inc   (count_en && word_bad),
        .cnt   (err_cnt)
    );

    lte_snap_bank #(.W(CNT_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctl.clear),
        .load    (ctl.enable || cap_pulse),
        .pass_in (pass_cnt),
        .err_in  (err_cnt),
        .pass_q  (pass_snap),
        .err_q   (err_snap)
    );

    lte_lock_qual #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl.clear),
        .enable   (ctl.enable),
        .word_vld (word_vld),
        .word_bad (word_bad),
        .done     (lock_done)
    );

    assign pass_wide = RB_W'(pass_snap);
    assign err_wide  = RB_W'(err_snap);

    // Decode the offset and select the control byte or one readback byte.
    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata[CTL_EN_BIT]   = ctl.enable;
            reg_rdata[CTL_CLR_BIT]  = ctl.clear;
            reg_rdata[CTL_LOCK_BIT] = lock_done;
        end
        for (int i = 0; i < REG_BYTES; i++) begin
            if (reg_addr == ADDR_W'(ERR_BASE + i))  reg_rdata = err_wide[i*8 +: 8];
            if (reg_addr == ADDR_W'(PASS_BASE + i)) reg_rdata = pass_wide[i*8 +: 8];
        end
    end

    // R3
    err_le_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= pass_cnt);

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.clear |=> (pass_cnt == '0 && err_cnt == '0 && pass_snap == '0));

    // R4
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.enable && !ctl.clear) |=> (pass_cnt == $past(pass_cnt) && err_cnt == $past(err_cnt)));

endmodule

// File: tb/lane_err_tally_bench.sv
module lane_err_tally_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam logic [63:0] TOPV = 64'd1023;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_vld = 1'b0;
    logic [31:0] err_mask = '0;
    logic [9:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        chk_reset;
    logic        lock_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_err_tally #(.CNT_W(CNT_W)) u_lane_err_tally (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .err_mask(err_mask),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .chk_reset(chk_reset), .lock_done(lock_done)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_cnt(logic [9:0] base, output logic [63:0] v);
        logic [7:0] b;
        v = '0;
        for (int i = 0; i < 7; i++) begin
            rd(base + 10'(i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic send(int n, logic [31:0] m);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            word_vld = 1'b1; err_mask = m;
        end
        @(negedge clk);
        word_vld = 1'b0; err_mask = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] c; logic [63:0] v;
        rd(10'h300, c);   check("R1", c, 0, "control after reset");
        rd_cnt(10'h301, v); check("R7", v, 0, "error count after reset");
        rd_cnt(10'h308, v); check("R7", v, 0, "word count after reset");
        check("R5", chk_reset, 0, "chk_reset after reset");
        check("R9", lock_done, 0, "lock after reset");
    endtask

    task automatic t_count();
        logic [7:0] c; logic [63:0] v;
        wr(10'h300, 8'h01);
        send(3, 32'h0);
        send(1, 32'h0000_0001);
        send(1, 32'hFFFF_FFFF);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); word_vld = 1'b0; err_mask = 32'hFF;
        end
        @(negedge clk); err_mask = '0;
        @(negedge clk);
        rd_cnt(10'h308, v); check("R2", v, 5, "words counted");
        rd_cnt(10'h301, v); check("R3", v, 2, "errored words counted");
        rd(10'h300, c);   check("R1", c, 8'h01, "control readback enable");
    endtask

    task automatic t_pause_capture();
        logic [7:0] c; logic [63:0] v;
        wr(10'h300, 8'h00);
        send(4, 32'h1);
        rd_cnt(10'h308, v); check("R4", v, 5, "word count held while disabled");
        rd_cnt(10'h301, v); check("R4", v, 2, "error count held while disabled");
        wr(10'h300, 8'h04);
        @(negedge clk);
        rd(10'h300, c);   check("R1", c, 8'h00, "capture bit reads 0");
        rd_cnt(10'h308, v); check("R6", v, 5, "captured word count");
        rd_cnt(10'h301, v); check("R6", v, 2, "captured error count");
        wr(10'h300, 8'h01);
        send(295, 32'h0);
        rd(10'h308, c); check("R7", c, 8'h2C, "word count byte 0");
        rd(10'h309, c); check("R7", c, 8'h01, "word count byte 1");
        rd(10'h30A, c); check("R7", c, 8'h00, "word count byte 2");
    endtask

    task automatic t_clear();
        logic [7:0] c; logic [63:0] v;
        wr(10'h300, 8'h03);
        check("R5", chk_reset, 1, "chk_reset while clear held");
        send(3, 32'h1);
        rd(10'h300, c);   check("R5", c, 8'h03, "control during clear, lock cleared");
        rd_cnt(10'h308, v); check("R5", v, 0, "word count under clear");
        rd_cnt(10'h301, v); check("R5", v, 0, "error count under clear");
        wr(10'h300, 8'h01);
        check("R5", chk_reset, 0, "chk_reset released");
    endtask

    task automatic t_lock();
        logic [7:0] c; logic [63:0] v;
        send(63, 32'h0);
        check("R9", lock_done, 0, "lock after 63 clean");
        send(1, 32'h0000_0100);
        send(63, 32'h0);
        check("R9", lock_done, 0, "lock after run broken");
        send(1, 32'h0);
        check("R9", lock_done, 1, "lock after 64 clean");
        rd(10'h300, c); check("R1", c, 8'h09, "control shows lock bit 3");
        send(1, 32'h1);
        check("R9", lock_done, 1, "lock sticky after error");
        rd_cnt(10'h308, v); check("R2", v, 129, "words over lock test");
        rd_cnt(10'h301, v); check("R3", v, 2, "errors over lock test");
        wr(10'h300, 8'h02);
        @(negedge clk);
        check("R9", lock_done, 0, "lock cleared");
        wr(10'h300, 8'h01);
    endtask

    task automatic t_saturate();
        logic [7:0] c; logic [63:0] v;
        send(1030, 32'h8000_0000);
        rd_cnt(10'h308, v); check("R8", v, TOPV, "word count saturates");
        rd_cnt(10'h301, v); check("R8", v, TOPV, "error count saturates");
        rd(10'h302, c); check("R7", c, 8'h03, "error byte 1 upper bits zero");
        rd(10'h303, c); check("R7", c, 8'h00, "error byte 2 zero");
    endtask

    task automatic t_other_addr();
        logic [7:0] c;
        wr(10'h301, 8'h00);
        wr(10'h200, 8'h02);
        @(negedge clk);
        rd(10'h301, c); check("R10", c, 8'hFF, "readback unchanged by write");
        rd(10'h300, c); check("R10", c, 8'h01, "control unchanged by stray write");
        check("R10", chk_reset, 0, "no clear from stray write");
        rd(10'h2FF, c); check("R10", c, 8'h00, "unmapped low offset");
        rd(10'h30F, c); check("R10", c, 8'h00, "unmapped high offset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_count();
        t_pause_capture();
        t_clear();
        t_lock();
        t_saturate();
        t_other_addr();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule